// File: doc/BRIEF.md
# Ping-Pong Frame Memory Switch

This block holds two frame memories of equal size. At any time one of them, the front bank, feeds the video read port through a 2:1 output selector. The other, the back bank, takes host writes. When a swap is requested, the roles of the two banks are exchanged by toggling the selector. The exchange is only allowed while the blanking input is high, so a visible frame never shows data from two banks.

Every accepted host write goes into the back bank in the same clock edge. A copy of the write is also placed in a short pending queue that targets the front bank. That queue only drains while blanking is high, at one entry per cycle, in the order the writes were accepted. A swap also waits until the queue is empty. Together these rules mean that after each exchange both banks hold the same contents.

A host write is accepted when `wr_valid` and `wr_ready` are both high at a rising clock edge. The video side presents a pixel address and receives that address's data from the front bank one cycle later. Pixel timing is generated outside this block.

Top module: `fb_pingpong`

## Requirements
- R1: After synchronous reset, `buf_sel` is 0, `wr_ready` is 1, and every address of both banks reads as 0.
- R2: `rd_data` shows the contents of the front bank at the `rd_addr` sampled on the previous rising edge. The front bank is bank 0 when `buf_sel` is 0 and bank 1 when `buf_sel` is 1, taking the `buf_sel` value from that same edge.
- R3: An accepted host write updates the back bank at its accepting edge. After the next swap, reading that address returns the written data.
- R4: While `blank` is low, the front bank is never modified, and the pending queue never shrinks.
- R5: During each cycle in which `blank` is high, one queued write, the oldest, is applied to the front bank. Once the queue is empty, both banks hold identical contents.
- R6: `buf_sel` changes only on an edge where `blank` was high. A `swap_req` pulse raised during active video is held until blanking allows the exchange.
- R7: A pending swap takes effect on the first edge with `blank` high and an empty queue. `wr_ready` is low in that cycle, so no write is accepted on the swap edge.
- R8: `wr_ready` is low whenever the pending queue holds QDEPTH entries (QDEPTH defaults to 4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Host write request |
| wr_ready | output | 1 | Host write can be accepted this cycle |
| wr_addr | input | 6 | Host write address |
| wr_data | input | 8 | Host write data |
| rd_addr | input | 6 | Video pixel address |
| rd_data | output | 8 | Front-bank data, one cycle after `rd_addr` |
| blank | input | 1 | High during the blanking interval |
| swap_req | input | 1 | Request to exchange bank roles |
| buf_sel | output | 1 | Index of the bank currently feeding video |

## Verification
The properties assume that `blank` and `swap_req` are clean synchronous levels. They also assume that the host only treats a write as done on an edge where `wr_ready` was high. The stimulus meets both conditions: all inputs change half a period away from the active edge, and a reference model retires a write only when it judges the handshake complete. Blanking follows a fixed repeating pattern of active and blank runs. This makes every drain and swap land inside a blank run, while random write and swap-request densities push the queue to full.

// File: rtl/fbsw_pkg.sv
package fbsw_pkg;
    localparam int ADDR_W = 6;
    localparam int DATA_W = 8;
    localparam int QDEPTH = 4;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;

    typedef struct packed {
        addr_t addr;
        data_t data;
    } wcmd_t;

    typedef enum logic {
        BANK_A = 1'b0,
        BANK_B = 1'b1
    } bank_e;

    function automatic bank_e other_bank(bank_e b);
        return (b == BANK_A) ? BANK_B : BANK_A;
    endfunction
endpackage

// File: rtl/fb_bank.sv
module fb_bank #(
    parameter int AW = 6,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int WORDS = 1 << AW;

    logic [DW-1:0] store [WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) store[i] <= '0;
            rdata <= '0;
        end else begin
            rdata <= store[raddr];
            if (we) store[waddr] <= wdata;
        end
    end
endmodule

// File: rtl/fb_pend_fifo.sv
module fb_pend_fifo
    import fbsw_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  wcmd_t         push_cmd,
    input  logic          pop,
    output wcmd_t         head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    wcmd_t         slots [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;

    function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign head  = slots[rd_ptr];
    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                slots[wr_ptr] <= push_cmd;
                wr_ptr        <= bump(wr_ptr);
            end
            if (pop) rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/fb_role_ctrl.sv
module fb_role_ctrl
    import fbsw_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  swap_req,
    input  logic  blank,
    input  logic  q_empty,
    output bank_e front,
    output logic  swap_now
);
    logic pending;

    assign swap_now = pending && blank && q_empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
            front   <= BANK_A;
        end else begin
            pending <= (pending || swap_req) && !swap_now;
            if (swap_now) front <= other_bank(front);
        end
    end
endmodule

// File: rtl/fb_pingpong.sv
module fb_pingpong
    import fbsw_pkg::*;
#(
    parameter int QDEPTH = fbsw_pkg::QDEPTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              blank,
    input  logic              swap_req,
    output logic              buf_sel
);
    localparam int CW = $clog2(QDEPTH + 1);

    bank_e         front, sel_q;
    logic          swap_now, host_acc, drain;
    logic          q_full, q_empty;
    logic [CW-1:0] q_cnt;
    wcmd_t         host_cmd, q_head;
    data_t         bank_q [2];

    assign host_cmd = '{addr: wr_addr, data: wr_data};
    assign wr_ready = !q_full && !swap_now;
    assign host_acc = wr_valid && wr_ready;
    assign drain    = blank && !q_empty;
    assign buf_sel  = front;

    fb_role_ctrl u_role (
        .clk      (clk),
        .rst      (rst),
        .swap_req (swap_req),
        .blank    (blank),
        .q_empty  (q_empty),
        .front    (front),
        .swap_now (swap_now)
    );

    fb_pend_fifo #(.DEPTH(QDEPTH)) u_pend (
        .clk      (clk),
        .rst      (rst),
        .push     (host_acc),
        .push_cmd (host_cmd),
        .pop      (drain),
        .head     (q_head),
        .count    (q_cnt),
        .full     (q_full),
        .empty    (q_empty)
    );

    for (genvar g = 0; g < 2; g++) begin : g_bank
        logic  is_front;
        logic  we;
        wcmd_t cmd;

        assign is_front = (front == bank_e'(g));
        assign we       = is_front ? drain : host_acc;
        assign cmd      = is_front ? q_head : host_cmd;

        fb_bank #(.AW(ADDR_W), .DW(DATA_W)) u_bank (
            .clk   (clk),
            .rst   (rst),
            .we    (we),
            .waddr (cmd.addr),
            .wdata (cmd.data),
            .raddr (rd_addr),
            .rdata (bank_q[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) sel_q <= BANK_A;
        else     sel_q <= front;
    end

    assign rd_data = bank_q[sel_q];
endmodule

// File: rtl/fb_pingpong_chk.sv
module fb_pingpong_chk #(
    parameter int QDEPTH = 4,
    parameter int CW = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          blank,
    input logic          wr_valid,
    input logic          wr_ready,
    input logic          buf_sel,
    input logic [CW-1:0] q_cnt
);
    AST_SWAP_IN_BLANK: assert property (@(posedge clk) disable iff (rst)
        !$stable(buf_sel) |-> $past(blank)); // R6

    AST_SWAP_AFTER_DRAIN: assert property (@(posedge clk) disable iff (rst)
        !$stable(buf_sel) |-> ($past(q_cnt) == '0)); // R7

    AST_NO_WRITE_AT_SWAP: assert property (@(posedge clk) disable iff (rst)
        !$stable(buf_sel) |-> !$past(wr_valid && wr_ready)); // R7

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (q_cnt == CW'(QDEPTH)) |-> !wr_ready); // R8

    AST_ACTIVE_NO_DRAIN: assert property (@(posedge clk) disable iff (rst)
        !blank |=> (q_cnt >= $past(q_cnt))); // R4
endmodule

bind fb_pingpong fb_pingpong_chk #(.QDEPTH(QDEPTH), .CW(CW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .blank    (blank),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .buf_sel  (buf_sel),
    .q_cnt    (q_cnt)
);

// File: tb/fb_pingpong_tb.sv
module fb_pingpong_tb;
    localparam int QD = 4;
    localparam int AW = 6;
    localparam int DW = 8;
    localparam int WORDS = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_valid = 1'b0, blank = 1'b0, swap_req = 1'b0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          wr_ready, buf_sel;
    logic [DW-1:0] rd_data;

    int n_chk = 0, n_bad = 0;

    logic [DW-1:0] mb [2][WORDS];
    logic [AW-1:0] mq_a [QD];
    logic [DW-1:0] mq_d [QD];
    int            mcnt = 0;
    logic          mfront = 1'b0, mpend = 1'b0;
    logic [DW-1:0] mrd = '0;

    always #10 clk = ~clk;

    fb_pingpong #(.QDEPTH(QD)) u_dut (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .blank(blank), .swap_req(swap_req), .buf_sel(buf_sel)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit model_ready();
        return (mcnt != QD) && !(mpend && blank && mcnt == 0);
    endfunction

    // One cycle: drive at negedge, check ready, update model after edge, check outputs.
    task automatic step(input bit v, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input bit sw, input bit bl, input logic [AW-1:0] ra);
        bit r, swp, acc;
        wr_valid = v; wr_addr = a; wr_data = d; swap_req = sw; blank = bl; rd_addr = ra;
        #1;
        r = model_ready();
        check(wr_ready == r, "R8 R7 wr_ready", wr_ready, r);
        @(posedge clk);
        swp = mpend && bl && mcnt == 0;
        acc = v && r;
        mrd = mb[mfront][ra];
        if (bl && mcnt > 0) begin
            mb[mfront][mq_a[0]] = mq_d[0];
            for (int i = 0; i < QD - 1; i++) begin
                mq_a[i] = mq_a[i+1];
                mq_d[i] = mq_d[i+1];
            end
            mcnt--;
        end
        if (acc) begin
            mb[!mfront][a] = d;
            mq_a[mcnt] = a;
            mq_d[mcnt] = d;
            mcnt++;
        end
        if (swp) mfront = !mfront;
        mpend = (mpend || sw) && !swp;
        @(negedge clk);
        check(rd_data == mrd, "R2 R3 R4 R5 rd_data", rd_data, mrd);
        check(buf_sel == mfront, "R6 R7 buf_sel", buf_sel, mfront);
    endtask

    initial begin
        #(200000 * 20);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
        $finish;
    end

    initial begin
        logic [DW-1:0] snap [WORDS];
        int ph;
        void'($urandom(32'd20240611));
        for (int b = 0; b < 2; b++)
            for (int i = 0; i < WORDS; i++) mb[b][i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        check(buf_sel == 1'b0, "R1 buf_sel", buf_sel, 0);
        check(wr_ready == 1'b1, "R1 wr_ready", wr_ready, 1);
        check(rd_data == '0, "R1 rd_data", rd_data, 0);
        for (int i = 0; i < WORDS; i++) step(0, 0, 0, 0, 0, AW'(i));

        // Directed: write during active video, front stays old (R4)
        step(1, 6'd5, 8'hA5, 0, 0, 6'd5);
        step(0, 0, 0, 0, 0, 6'd5);
        step(0, 0, 0, 0, 0, 6'd5);
        check(rd_data == 8'h00, "R4 front untouched", rd_data, 0);
        step(1, 6'd6, 8'h16, 0, 0, 0);
        step(1, 6'd7, 8'h17, 0, 0, 0);
        step(1, 6'd8, 8'h18, 0, 0, 0);
        #1 check(wr_ready == 1'b0, "R8 full queue", wr_ready, 0);
        // Swap requested in active video: held (R6)
        step(0, 0, 0, 1, 0, 0);
        for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 0, 0);
        check(buf_sel == 1'b0, "R6 no swap in active", buf_sel, 0);
        // Blanking: four drains then swap on the fifth edge (R5, R7)
        for (int i = 0; i < 4; i++) begin
            step(0, 0, 0, 0, 1, 6'd5);
            check(buf_sel == 1'b0, "R7 swap waits for drain", buf_sel, 0);
        end
        step(0, 0, 0, 0, 1, 6'd5);
        check(buf_sel == 1'b1, "R7 swap after drain", buf_sel, 1);
        step(0, 0, 0, 0, 0, 6'd5);
        check(rd_data == 8'hA5, "R3 new front has write", rd_data, 8'hA5);

        // Random traffic
        for (int c = 0; c < 3000; c++) begin
            ph = c % 24;
            step(($urandom % 100) < 55, AW'($urandom), DW'($urandom),
                 ($urandom % 100) < 6, ph >= 18, AW'($urandom));
        end

        // R5: drain all, compare both banks across a swap
        for (int i = 0; i < 8; i++) step(0, 0, 0, 0, 1, 0);
        for (int i = 0; i <= WORDS; i++) begin
            step(0, 0, 0, 0, 0, AW'(i % WORDS));
            if (i > 0) snap[i-1] = rd_data;
        end
        step(0, 0, 0, 1, 0, 0);
        step(0, 0, 0, 0, 1, 0);
        step(0, 0, 0, 0, 0, 0);
        for (int i = 0; i <= WORDS; i++) begin
            step(0, 0, 0, 0, 0, AW'(i % WORDS));
            if (i > 0) check(rd_data == snap[i-1], "R5 banks identical", rd_data, snap[i-1]);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule